// File: doc/BRIEF.md
# Link Reset Request Output Controller

This block drives the enable of an external open-drain, active-low software reset line. Any of the link ports may report that its link partner sent a valid reset request; each report arrives as a one-cycle pulse. The block records every pulse in a sticky per-port status bit and turns on the pin enable. When the enable is 1 the pad pulls the line low. When it is 0 the pad releases the line to its external pull-up.

How long the line stays low depends on a mode input. With self-reset off, the line stays low until software has cleared every recorded request through a write-one-to-clear access. With self-reset on, the line stays low until the reset sequencer reports that the self-reset has finished. That completion also wipes the recorded requests. The asynchronous hard reset clears everything. The line then stays released after the hard reset ends, until a new request arrives.

Top module: `link_rst_req_ctrl`

## Requirements
- R1: A pulse on any bit of `req_pulse` makes `pin_oe` 1 on the clock edge that samples it, so `pin_oe` reads 1 one cycle after the pulse.
- R2: Bit i of `req_status` is set by the edge that samples `req_pulse[i]`. It then stays set until it is explicitly cleared.
- R3: A cycle with `clr_wr`=1 clears each `req_status` bit whose `clr_mask` bit is 1 and keeps bits whose mask bit is 0. A request on a port in the same cycle as its clear leaves that bit set.
- R4: With `self_rst_en`=0, `pin_oe` equals the OR of `req_status` after every edge. The enable drops in the same cycle the last status bit is cleared.
- R5: With `self_rst_en`=1, `pin_oe` stays 1 once set, even when software clears all status bits, until `self_rst_done` is seen.
- R6: With `self_rst_en`=1 and no request in the same cycle, `self_rst_done`=1 makes `pin_oe` 0 and clears all of `req_status` on the next edge. With `self_rst_en`=0, `self_rst_done` has no effect on either output.
- R7: A request that arrives while `pin_oe` is 1 sets its status bit, and `pin_oe` stays 1 without any low cycle. A request in the same cycle as `self_rst_done` keeps `pin_oe` at 1.
- R8: `hard_rst_n`=0 forces `pin_oe` and `req_status` to 0 at once, without a clock edge. Both stay 0 after release until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous hard reset, active low |
| req_pulse | input | NPORT | One-cycle valid reset request per link port (bit i = port i) |
| self_rst_en | input | 1 | 1 = self-reset mode, 0 = hold until software clear |
| clr_wr | input | 1 | Status clear write strobe from the register bus |
| clr_mask | input | NPORT | Write-one-to-clear data for `req_status` (bit i = port i) |
| self_rst_done | input | 1 | Strobe from the reset sequencer: self-reset complete |
| pin_oe | output | 1 | 1 = pull the reset line low, 0 = release it |
| req_status | output | NPORT | Sticky per-port reset request record |

## Verification
The bench builds the block with the default of eight ports. The whole status vector is then visible, so one stimulus can make several ports request at once, for example the pattern 8'hC3 with both end ports. With eight ports, a clear can leave some bits set and remove others, which tests the OR-based release at a width where a one-bit mistake shows. It can also reach the corner cases where a request meets a clear or a completion strobe in the same cycle.

// File: rtl/lrr_pkg.sv
package lrr_pkg;

  typedef enum logic {
    OE_OFF = 1'b0,
    OE_ON  = 1'b1
  } oe_state_e;

  // next value of one sticky status bit: a request wins over any wipe
  function automatic logic stat_bit_next(input logic cur,
                                         input logic set,
                                         input logic wipe);
    return set | (cur & ~wipe);
  endfunction

  // next state of the pin enable
  function automatic oe_state_e oe_next(input oe_state_e cur,
                                        input logic      any_set,
                                        input logic      self_mode,
                                        input logic      done,
                                        input logic      any_stat_next);
    oe_state_e nxt;
    if (any_set)        nxt = OE_ON;
    else if (self_mode) nxt = done ? OE_OFF : cur;
    else                nxt = any_stat_next ? OE_ON : OE_OFF;
    return nxt;
  endfunction

endpackage

// File: rtl/lrr_status_bank.sv
module lrr_status_bank #(
  parameter int NPORT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] set_vec,
  input  logic [NPORT-1:0] wipe_vec,
  output logic [NPORT-1:0] stat_q,
  output logic [NPORT-1:0] stat_d
);
  import lrr_pkg::*;

  for (genvar i = 0; i < NPORT; i++) begin : g_bit
    always_comb stat_d[i] = stat_bit_next(stat_q[i], set_vec[i], wipe_vec[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= stat_d[i];
    end
  end

endmodule

// File: rtl/lrr_hold_ctrl.sv
module lrr_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic any_set,
  input  logic self_mode,
  input  logic done,
  input  logic any_stat_next,
  output logic oe
);
  import lrr_pkg::*;

  oe_state_e state_q, state_d;

  always_comb state_d = oe_next(state_q, any_set, self_mode, done, any_stat_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= OE_OFF;
    else        state_q <= state_d;
  end

  assign oe = (state_q == OE_ON);

endmodule

// File: rtl/link_rst_req_ctrl.sv
module link_rst_req_ctrl #(
  parameter int NPORT = 8
) (
  input  logic             clk,
  input  logic             hard_rst_n,
  input  logic [NPORT-1:0] req_pulse,
  input  logic             self_rst_en,
  input  logic             clr_wr,
  input  logic [NPORT-1:0] clr_mask,
  input  logic             self_rst_done,
  output logic             pin_oe,
  output logic [NPORT-1:0] req_status
);
  localparam logic [NPORT-1:0] NONE = '0;
  localparam logic [NPORT-1:0] ALL  = '1;

  // named internal events
  logic             any_req_evt;
  logic             self_wipe_evt;
  logic [NPORT-1:0] sw_clr_vec;
  logic [NPORT-1:0] wipe_vec;
  logic [NPORT-1:0] stat_d;
  logic             any_stat_next;

  assign any_req_evt   = |req_pulse;
  assign self_wipe_evt = self_rst_en & self_rst_done;
  assign sw_clr_vec    = clr_wr ? clr_mask : NONE;
  assign wipe_vec      = sw_clr_vec | (self_wipe_evt ? ALL : NONE);
  assign any_stat_next = |stat_d;

  lrr_status_bank #(.NPORT(NPORT)) u_bank (
    .clk      (clk),
    .rst_n    (hard_rst_n),
    .set_vec  (req_pulse),
    .wipe_vec (wipe_vec),
    .stat_q   (req_status),
    .stat_d   (stat_d)
  );

  lrr_hold_ctrl u_hold (
    .clk           (clk),
    .rst_n         (hard_rst_n),
    .any_set       (any_req_evt),
    .self_mode     (self_rst_en),
    .done          (self_rst_done),
    .any_stat_next (any_stat_next),
    .oe            (pin_oe)
  );

endmodule

// File: rtl/link_rst_req_ctrl_chk.sv
module link_rst_req_ctrl_chk #(
  parameter int NPORT = 8
) (
  input logic             clk,
  input logic             hard_rst_n,
  input logic [NPORT-1:0] req_pulse,
  input logic             self_rst_en,
  input logic             clr_wr,
  input logic [NPORT-1:0] clr_mask,
  input logic             self_rst_done,
  input logic             pin_oe,
  input logic [NPORT-1:0] req_status,
  input logic             any_req_evt,
  input logic             self_wipe_evt
);

  a_r1_req_asserts: assert property (@(posedge clk) disable iff (!hard_rst_n)
    any_req_evt |=> pin_oe);

  a_r2_status_set: assert property (@(posedge clk) disable iff (!hard_rst_n)
    any_req_evt |=> ((req_status & $past(req_pulse)) == $past(req_pulse)));

  a_r3_w1c_clear: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (clr_wr && !any_req_evt) |=> ((req_status & $past(clr_mask)) == '0));

  a_r4_sw_follows_status: assert property (@(posedge clk) disable iff (!hard_rst_n)
    !self_rst_en |=> (pin_oe == (req_status != '0)));

  a_r5_self_hold: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (self_rst_en && pin_oe && !self_rst_done) |=> pin_oe);

  a_r6_done_release: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (self_wipe_evt && !any_req_evt) |=> (!pin_oe && req_status == '0));

  a_r7_no_glitch: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (pin_oe && any_req_evt) |=> pin_oe);

  always @(posedge clk) begin
    if (!hard_rst_n) begin
      a_r8_reset_clear: assert (!pin_oe && req_status == '0);
    end
  end

endmodule

bind link_rst_req_ctrl link_rst_req_ctrl_chk #(.NPORT(NPORT)) u_chk (
  .clk           (clk),
  .hard_rst_n    (hard_rst_n),
  .req_pulse     (req_pulse),
  .self_rst_en   (self_rst_en),
  .clr_wr        (clr_wr),
  .clr_mask      (clr_mask),
  .self_rst_done (self_rst_done),
  .pin_oe        (pin_oe),
  .req_status    (req_status),
  .any_req_evt   (any_req_evt),
  .self_wipe_evt (self_wipe_evt)
);

// File: tb/test_link_rst_req_ctrl.sv
`timescale 1ns/1ps
module test_link_rst_req_ctrl;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          hard_rst_n = 1'b1;
  logic [NP-1:0] req_pulse = '0;
  logic          self_rst_en = 1'b0;
  logic          clr_wr = 1'b0;
  logic [NP-1:0] clr_mask = '0;
  logic          self_rst_done = 1'b0;
  logic          pin_oe;
  logic [NP-1:0] req_status;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic          oe;
    logic [NP-1:0] st;
    string         tag;
  } exp_t;
  exp_t sb[$];

  // bench model state
  logic          m_oe = 1'b0;
  logic [NP-1:0] m_st = '0;

  always #2 clk = ~clk;  // 250 MHz

  link_rst_req_ctrl #(.NPORT(NP)) i_link_rst_req_ctrl (
    .clk(clk), .hard_rst_n(hard_rst_n), .req_pulse(req_pulse),
    .self_rst_en(self_rst_en), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .self_rst_done(self_rst_done), .pin_oe(pin_oe), .req_status(req_status)
  );

  task automatic check(input string tag, input logic oe_a, input logic [NP-1:0] st_a,
                       input logic oe_e, input logic [NP-1:0] st_e);
    checks++;
    if (oe_a !== oe_e || st_a !== st_e) begin
      errors++;
      $display("FAIL %s: pin_oe=%b req_status=%h expected pin_oe=%b req_status=%h",
               tag, oe_a, st_a, oe_e, st_e);
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input logic [NP-1:0] req, input logic clr, input logic [NP-1:0] mask,
                      input logic self_m, input logic done, input string tag);
    exp_t e;
    logic [NP-1:0] kept;
    @(negedge clk);
    req_pulse = req; clr_wr = clr; clr_mask = mask;
    self_rst_en = self_m; self_rst_done = done;
    kept = m_st;
    if (clr) kept = kept & ~mask;
    if (self_m && done) kept = '0;
    m_st = kept | req;
    if (req != '0)   m_oe = 1'b1;
    else if (self_m) m_oe = done ? 1'b0 : m_oe;
    else             m_oe = (m_st != '0);
    e.oe = m_oe; e.st = m_st; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare just after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, pin_oe, req_status, e.oe, e.st);
      end
    end
  end

  task automatic drain();
    step('0, 1'b0, '0, self_rst_en, 1'b0, "idle");
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1 hard_rst_n = 1'b0;
    #9;
    check("R8 reset state", pin_oe, req_status, 1'b0, '0);
    @(negedge clk) hard_rst_n = 1'b1;
    step('0,       0, '0,    0, 0, "R8 stays released after reset");
    step(8'h08,    0, '0,    0, 0, "R1 R2 port3 request");
    step('0,       0, '0,    0, 0, "R2 sticky");
    step(8'h20,    0, '0,    0, 0, "R7 new request while asserted");
    step('0,       1, 8'h08, 0, 0, "R3 R4 partial clear keeps enable");
    step(8'h01,    1, 8'h21, 0, 0, "R3 request wins over clear");
    step('0,       1, 8'h01, 0, 0, "R4 last clear releases");
    step(8'hC3,    0, '0,    0, 0, "R2 multi-port request");
    step('0,       0, '0,    0, 1, "R6 done ignored without self-reset");
    step('0,       1, 8'h00, 0, 0, "R3 zero mask keeps bits");
    step('0,       1, 8'hC3, 0, 0, "R4 clear all releases");
    step(8'h04,    0, '0,    1, 0, "R1 self mode request");
    step('0,       1, 8'h04, 1, 0, "R5 clear does not release");
    step('0,       0, '0,    1, 0, "R5 still held");
    step(8'h02,    0, '0,    1, 0, "R7 request in self mode");
    step('0,       0, '0,    1, 1, "R6 done releases and wipes");
    step('0,       0, '0,    1, 0, "R6 stays released");
    step(8'h10,    0, '0,    1, 0, "R1 self request again");
    step(8'h80,    0, '0,    1, 1, "R7 request with done keeps enable");
    step('0,       0, '0,    0, 0, "R7 held after done collision");
    drain();
    // asynchronous hard reset while asserted
    #0.5 hard_rst_n = 1'b0;
    #0.5;
    check("R8 async reset clears", pin_oe, req_status, 1'b0, '0);
    m_oe = 1'b0; m_st = '0;
    @(negedge clk) hard_rst_n = 1'b1;
    step('0, 0, '0, 0, 0, "R8 released after hard reset");
    step('0, 0, '0, 1, 0, "R8 released in self mode");
    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule